// File: doc/BRIEF.md
# Audio Transmit FIFO Register Front End

This block sits between a simple 32-bit register bus and the serializer of an audio playback path. Software programs a configuration word and pushes sample words, left then right, through a single data port. The words queue in an on-chip transmit FIFO, and the serializer drains that FIFO through a first-word-fall-through read port. The configuration fields are also driven out to the serializer: transmit enable, left-channel control, clock ratio, sample resolution and channel field.

Two interrupt sources watch the FIFO. The underrun source fires while the FIFO is empty. The level source fires while occupancy is below a low-water trigger. The trigger is the FIFO depth shifted right by a 4-bit level code, so code 1 means half full. Each source latches into a status bit. A software write of 1 clears the bit, and it sets again on the following clock if its condition still holds. The interrupt line is the OR of the latched, unmasked sources, gated by a global interrupt enable.

Top module: `atx_front`

## Requirements
- R1: Word offset 0x00 reads the VERSION parameter. Writes to it change nothing.
- R2: Offset 0x04 holds the configuration, which is 0 after reset. Bit 0 is transmit enable, bit 1 interrupt enable and bit 2 left control. Bits 15:8 hold the ratio, 21:16 the resolution, 27:24 the level code and 31:28 the channel field. All other bits read 0. The fields drive the matching cfg_* outputs.
- R3: A write to offset 0x10 pushes the write data when the FIFO is not full. fifo_level rises by one after that clock edge, and ser_data presents the words in the order they were written.
- R4: A write to 0x10 while the FIFO holds FIFO_DEPTH words is dropped. The occupancy stays at FIFO_DEPTH and the queued words are unchanged.
- R5: Writes to offsets 0x14, 0x18 and 0x1C push nothing. Reads of 0x10 to 0x1C return 0.
- R6: ser_pop removes the head word when ser_empty is low and is ignored when ser_empty is high. A push and a pop in the same cycle leave the occupancy unchanged.
- R7: Status bit 0 (underrun) is set on the clock after the FIFO is seen empty. It stays set until cleared.
- R8: Status bit 1 (level) is set on the clock after occupancy is below FIFO_DEPTH >> code with a nonzero code. Code 0 never sets it, and neither does a code whose shifted threshold is 0.
- R9: Writing 1 to a bit of offset 0x0C clears that status bit at that edge, and writing 0 leaves it alone. If the condition persists, the bit reads 1 again one cycle later.
- R10: Offset 0x08 holds the mask in bits 1:0 (bit 0 underrun, bit 1 level). Other bits read 0.
- R11: irq equals interrupt enable AND the OR of (status AND mask), with no added delay.
- R12: After reset the configuration, mask and status are 0, the FIFO is empty and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ser_pop | input | 1 | Serializer takes the head word |
| ser_data | output | 32 | Head word of the FIFO |
| ser_empty | output | 1 | FIFO holds no word |
| fifo_level | output | clog2(FIFO_DEPTH+1) | Current occupancy |
| cfg_tx_en | output | 1 | Transmit enable field |
| cfg_left | output | 1 | Left-channel control field |
| cfg_ratio | output | 8 | Clock ratio field |
| cfg_res | output | 6 | Sample resolution field |
| cfg_chan | output | 4 | Channel field |
| irq | output | 1 | Interrupt request |

## Verification
A bus push and a serializer pop can land on the same edge, and the FIFO must then keep its occupancy while rotating its contents. This includes the case where the FIFO is full, and there the push must be dropped even though a slot opens in that cycle. The bench provokes this both in directed steps at chosen levels and in a long random phase where pushes and pops are each requested in close to half the cycles. Every cycle, the occupancy, head word and status register are compared with a queue model that applies the pre-edge full and empty conditions.

// File: rtl/atx_pkg.sv
package atx_pkg;

  localparam int unsigned DW = 32;

  // word indices (byte address >> 2)
  localparam logic [2:0] WI_VER  = 3'd0;
  localparam logic [2:0] WI_CFG  = 3'd1;
  localparam logic [2:0] WI_MSK  = 3'd2;
  localparam logic [2:0] WI_STA  = 3'd3;
  localparam logic [2:0] WI_DAT0 = 3'd4;

  // interrupt sources
  localparam int unsigned NSRC      = 2;
  localparam int unsigned SRC_UNDER = 0;
  localparam int unsigned SRC_LEVEL = 1;

  // bits of the configuration word that hold state
  localparam logic [31:0] CFG_WMASK = 32'hFF3F_FF07;

  typedef struct packed {
    logic [3:0] chan;
    logic [3:0] lvl;
    logic [1:0] rsv1;
    logic [5:0] res;
    logic [7:0] ratio;
    logic [4:0] rsv0;
    logic       left;
    logic       int_en;
    logic       tx_en;
  } cfg_t;

  // low-water trigger: depth divided by 2**code, code 0 means off
  function automatic int unsigned low_water(input int unsigned depth,
                                            input logic [3:0] code);
    if (code == 4'd0) return 0;
    return depth >> code;
  endfunction

  function automatic logic below_trigger(input int unsigned occ,
                                         input int unsigned depth,
                                         input logic [3:0] code);
    return (code != 4'd0) && (occ < low_water(depth, code));
  endfunction

endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  // named internal events
  logic push_ok, pop_ok, push_drop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign push_ok   = push && !full;
  assign pop_ok    = pop && !empty;
  assign push_drop = push && full;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign count   = cnt_q;

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  p_drop_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop) |=> (cnt_q == CNT_W'(DEPTH)));

  p_push_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

  p_both_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(cnt_q));

endmodule

// File: rtl/atx_regs.sv
module atx_regs
  import atx_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter logic [31:0] VERSION = 32'h0002_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSRC-1:0]   stat,
  output cfg_t              cfg,
  output logic [NSRC-1:0]   mask,
  output logic [NSRC-1:0]   clr,
  output logic              push_req,
  output logic [DW-1:0]     push_data
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic hit_ver, hit_cfg, hit_msk, hit_sta, hit_dat0, hit_datx;
  logic wr_cfg, wr_msk, wr_sta;

  cfg_t            cfg_q;
  logic [NSRC-1:0] mask_q;

  assign widx     = bus_addr[ADDR_W-1:2];
  assign hit_ver  = (widx == WIDX_W'(WI_VER));
  assign hit_cfg  = (widx == WIDX_W'(WI_CFG));
  assign hit_msk  = (widx == WIDX_W'(WI_MSK));
  assign hit_sta  = (widx == WIDX_W'(WI_STA));
  assign hit_dat0 = (widx == WIDX_W'(WI_DAT0));
  assign hit_datx = (widx > WIDX_W'(WI_DAT0)) && (widx <= WIDX_W'(WI_DAT0 + 3'd3));

  assign wr_cfg = bus_wr && hit_cfg;
  assign wr_msk = bus_wr && hit_msk;
  assign wr_sta = bus_wr && hit_sta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_cfg) cfg_q  <= cfg_t'(bus_wdata & CFG_WMASK);
      if (wr_msk) mask_q <= bus_wdata[NSRC-1:0];
    end
  end

  assign clr       = wr_sta ? bus_wdata[NSRC-1:0] : '0;
  assign push_req  = bus_wr && hit_dat0;
  assign push_data = bus_wdata;
  assign cfg       = cfg_q;
  assign mask      = mask_q;

  always_comb begin
    bus_rdata = '0;
    if (hit_ver)      bus_rdata = VERSION;
    else if (hit_cfg) bus_rdata = cfg_q;
    else if (hit_msk) bus_rdata = DW'(mask_q);
    else if (hit_sta) bus_rdata = DW'(stat);
  end

  p_ver_ro_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ver |-> (bus_rdata == VERSION));

  p_dat_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_dat0 || hit_datx) |-> (bus_rdata == '0));

  p_cfg_rsv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q & ~CFG_WMASK) == '0));

endmodule

// File: rtl/atx_irq.sv
module atx_irq
  import atx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] occ,
  input  logic                       empty,
  input  logic [3:0]                 lvl_code,
  input  logic [NSRC-1:0]            clr,
  input  logic [NSRC-1:0]            mask,
  input  logic                       int_en,
  output logic [NSRC-1:0]            stat,
  output logic                       irq
);
  logic [NSRC-1:0] cond;
  logic [NSRC-1:0] stat_q;

  assign cond[SRC_UNDER] = empty;
  assign cond[SRC_LEVEL] = below_trigger(32'(occ), DEPTH, lvl_code);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)      stat_q[i] <= 1'b0;
      else if (clr[i]) stat_q[i] <= 1'b0;
      else             stat_q[i] <= stat_q[i] | cond[i];
    end

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !stat_q[i]);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr[i]) |=> stat_q[i]);
  end

  assign stat = stat_q;
  assign irq  = int_en & |(stat_q & mask);

  p_under_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !clr[SRC_UNDER]) |=> stat_q[SRC_UNDER]);

  p_level_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cond[SRC_LEVEL] && !clr[SRC_LEVEL]) |=> stat_q[SRC_LEVEL]);

  p_level_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_code == 4'd0) && !stat_q[SRC_LEVEL]) |=> !stat_q[SRC_LEVEL]);

endmodule

// File: rtl/atx_front.sv
module atx_front
  import atx_pkg::*;
#(
  parameter int          ADDR_W     = 5,
  parameter int          FIFO_DEPTH = 64,
  parameter logic [31:0] VERSION    = 32'h0002_0001
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [31:0]                     bus_wdata,
  output logic [31:0]                     bus_rdata,
  input  logic                            ser_pop,
  output logic [31:0]                     ser_data,
  output logic                            ser_empty,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
  output logic                            cfg_tx_en,
  output logic                            cfg_left,
  output logic [7:0]                      cfg_ratio,
  output logic [5:0]                      cfg_res,
  output logic [3:0]                      cfg_chan,
  output logic                            irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  cfg_t            cfg;
  logic [NSRC-1:0] mask, clr, stat;
  logic            push_req;
  logic [DW-1:0]   push_data;
  logic [CNT_W-1:0] count;
  logic            empty, full;

  atx_regs #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat(stat), .cfg(cfg),
    .mask(mask), .clr(clr), .push_req(push_req), .push_data(push_data)
  );

  atx_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_req), .push_data(push_data),
    .pop(ser_pop), .rd_data(ser_data), .count(count), .empty(empty), .full(full)
  );

  atx_irq #(.DEPTH(FIFO_DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .occ(count), .empty(empty), .lvl_code(cfg.lvl),
    .clr(clr), .mask(mask), .int_en(cfg.int_en), .stat(stat), .irq(irq)
  );

  assign ser_empty  = empty;
  assign fifo_level = count;
  assign cfg_tx_en  = cfg.tx_en;
  assign cfg_left   = cfg.left;
  assign cfg_ratio  = cfg.ratio;
  assign cfg_res    = cfg.res;
  assign cfg_chan   = cfg.chan;

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.int_en |-> !irq);

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & mask) == '0) |-> !irq);

endmodule

// File: tb/atx_front_tb.sv
module atx_front_tb;
  localparam int          DEPTH = 64;
  localparam int          CW    = $clog2(DEPTH + 1);
  localparam logic [31:0] VER   = 32'h0002_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_pop = 1'b0;
  logic [31:0] ser_data;
  logic        ser_empty;
  logic [CW-1:0] fifo_level;
  logic        cfg_tx_en, cfg_left, irq;
  logic [7:0]  cfg_ratio;
  logic [5:0]  cfg_res;
  logic [3:0]  cfg_chan;

  always #4 clk = ~clk;

  atx_front #(.ADDR_W(5), .FIFO_DEPTH(DEPTH), .VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_pop(ser_pop),
    .ser_data(ser_data), .ser_empty(ser_empty), .fifo_level(fifo_level),
    .cfg_tx_en(cfg_tx_en), .cfg_left(cfg_left), .cfg_ratio(cfg_ratio),
    .cfg_res(cfg_res), .cfg_chan(cfg_chan), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // model state
  logic [31:0] mq[$];
  logic [31:0] m_cfg = '0;
  logic [1:0]  m_msk = '0;
  logic [1:0]  m_stat = '0;

  function automatic int thr_of(input logic [3:0] code);
    int t = DEPTH;
    if (code == 0) return 0;
    for (int k = 0; k < int'(code); k++) t = t / 2;
    return t;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  task automatic model_edge(input logic wr, input logic [4:0] a,
                            input logic [31:0] wd, input logic pop);
    logic [2:0] wi = a[4:2];
    logic [1:0] cl = (wr && wi == 3'd3) ? wd[1:0] : 2'b00;
    logic [3:0] code = m_cfg[27:24];
    logic cu = (mq.size() == 0);
    logic lv = (code != 0) && (mq.size() < thr_of(code));
    logic do_push = wr && wi == 3'd4 && mq.size() < DEPTH;
    logic do_pop  = pop && mq.size() > 0;
    m_stat[0] = cl[0] ? 1'b0 : (m_stat[0] | cu);
    m_stat[1] = cl[1] ? 1'b0 : (m_stat[1] | lv);
    if (do_pop) void'(mq.pop_front());
    if (do_push) mq.push_back(wd);
    if (wr && wi == 3'd1) m_cfg = wd & 32'hFF3F_FF07;
    if (wr && wi == 3'd2) m_msk = wd[1:0];
  endtask

  task automatic compare_outputs();
    chk("R3 level", 32'(fifo_level), 32'(mq.size()));
    chk("R6 empty", 32'(ser_empty), 32'(mq.size() == 0));
    if (mq.size() > 0) chk("R3 head", ser_data, mq[0]);
    chk("R11 irq", 32'(irq), 32'(m_cfg[1] & |(m_stat & m_msk)));
    chk("R2 outs", {cfg_chan, cfg_res, cfg_ratio, cfg_left, cfg_tx_en},
        {m_cfg[31:28], m_cfg[21:16], m_cfg[15:8], m_cfg[2], m_cfg[0]});
    bus_addr = 5'h0C;
    #1;
    chk("R7/R8 status", bus_rdata, 32'(m_stat));
  endtask

  task automatic step(input logic wr, input logic [4:0] a,
                      input logic [31:0] wd, input logic pop);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; ser_pop = pop;
    @(posedge clk);
    model_edge(wr, a, wd, pop);
    @(negedge clk);
    bus_wr = 1'b0; ser_pop = 1'b0;
    compare_outputs();
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state before the first active edge
    rd_chk(5'h04, 32'h0, "R12 cfg");
    rd_chk(5'h08, 32'h0, "R12 mask");
    rd_chk(5'h0C, 32'h0, "R12 status");
    chk("R12 level", 32'(fifo_level), 32'h0);
    chk("R12 irq", 32'(irq), 32'h0);

    // R1: version is read-only
    step(1, 5'h00, 32'hFFFF_FFFF, 0);
    rd_chk(5'h00, VER, "R1 version");

    // R2: config writable fields
    step(1, 5'h04, 32'hFFFF_FFFF, 0);
    rd_chk(5'h04, 32'hFF3F_FF07, "R2 cfg mask");
    step(1, 5'h04, 32'h0100_0002, 0);   // int enable, level code 1

    // R10: mask register
    step(1, 5'h08, 32'hFFFF_FFFF, 0);
    rd_chk(5'h08, 32'h3, "R10 mask");

    // R9: clear while empty, re-assert a cycle later
    step(1, 5'h0C, 32'h1, 0);
    rd_chk(5'h0C, 32'(m_stat), "R9 cleared");
    chk("R9 bit0 low", 32'(m_stat[0]), 32'h0);
    step(0, 5'h00, 0, 0);
    rd_chk(5'h0C, 32'h3, "R9 reasserted");

    // R3: fill to full
    for (int i = 0; i < DEPTH; i++) step(1, 5'h10, 32'hA500_0000 + i, 0);
    chk("R3 full level", 32'(fifo_level), DEPTH);

    // R4: push while full is dropped
    step(1, 5'h10, 32'hDEAD_BEEF, 0);
    chk("R4 level", 32'(fifo_level), DEPTH);
    chk("R4 head", ser_data, 32'hA500_0000);
    step(1, 5'h10, 32'hDEAD_BEEF, 1);   // full: pop accepted, push dropped
    chk("R4 drop with pop", 32'(fifo_level), DEPTH - 1);

    // R8: level source with code 1 (threshold half depth)
    step(1, 5'h0C, 32'h3, 0);
    for (int i = 0; i < 32; i++) step(0, 5'h00, 0, 1);
    step(0, 5'h00, 0, 0);
    rd_chk(5'h0C, 32'h2, "R8 level set");

    // R6: push and pop in the same cycle
    step(1, 5'h10, 32'h1234_5678, 1);
    chk("R6 same cycle", 32'(fifo_level), 31);

    // R8: code 0 and code 15 never set level
    step(1, 5'h04, 32'h0000_0002, 0);
    step(1, 5'h0C, 32'h3, 0);
    repeat (3) step(0, 5'h00, 0, 0);
    rd_chk(5'h0C, 32'h0, "R8 code zero");
    step(1, 5'h04, 32'h0F00_0002, 0);
    repeat (3) step(0, 5'h00, 0, 0);
    rd_chk(5'h0C, 32'h0, "R8 code fifteen");

    // R5: other data ports push nothing and read zero
    step(1, 5'h14, 32'h1111_1111, 0);
    step(1, 5'h18, 32'h2222_2222, 0);
    step(1, 5'h1C, 32'h3333_3333, 0);
    chk("R5 no push", 32'(fifo_level), 31);
    rd_chk(5'h10, 32'h0, "R5 read dat0");
    rd_chk(5'h1C, 32'h0, "R5 read dat3");

    // R6: drain then pop on empty
    while (mq.size() > 0) step(0, 5'h00, 0, 1);
    repeat (3) step(0, 5'h00, 0, 1);
    chk("R6 empty pop", 32'(fifo_level), 0);

    // R7 / R11: underrun interrupt gating
    step(0, 5'h00, 0, 0);
    rd_chk(5'h0C, 32'h1, "R7 underrun");
    step(1, 5'h04, 32'h0000_0002, 0);
    chk("R11 irq on", 32'(irq), 32'h1);
    step(1, 5'h08, 32'h2, 0);
    chk("R11 masked", 32'(irq), 32'h0);
    step(1, 5'h08, 32'h3, 0);
    step(1, 5'h04, 32'h0000_0000, 0);
    chk("R11 disabled", 32'(irq), 32'h0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      logic p = ($urandom % 100) < 45;
      if (r < 45)      step(1, 5'h10, $urandom, p);
      else if (r < 55) step(1, 5'h0C, $urandom, p);
      else if (r < 60) step(1, 5'h04, $urandom, p);
      else if (r < 63) step(1, 5'h08, $urandom, p);
      else if (r < 66) step(1, 5'(5'h14 + 4 * ($urandom % 3)), $urandom, p);
      else             step(0, 5'h00, 0, p);
    end

    summary();
    $finish;
  end
endmodule